// File: doc/BRIEF.md
# SAR Converter Serial Readout Port

This block is the device-side digital interface of a 14-bit successive-approximation converter, used in a four-wire chip-select mode that signals the end of conversion on the data line. A host raises the convert pin while holding the serial-select pin high. This starts a conversion and releases the data line to high impedance. When the abstracted converter core reports that it is done, the port drives the data line low. With a pull-up on the board, that falling level serves as an interrupt to the host. The host then clocks the result out on the serial clock.

The three host pins are asynchronous to the system clock. Each passes through a two-stage synchronizer, and edges are detected on the synchronized levels. The port issues a one-cycle start strobe to the converter core. It captures the core's result when the done strobe arrives, and presents the bits most significant first, advancing on each serial-clock falling edge. The converter core is modelled outside this block. Its conversion time is the number of system cycles it takes between the start and done strobes.

The busy indication is only guaranteed when the serial-select pin is low from the minimum conversion time onward. A conversion during which the pin is seen high at or after that point produces no low level and no readback.

Top module: `adc_serial_port`

## Requirements
- R1: A rising edge on the synchronized convert pin while the synchronized select pin is high starts a conversion: the port pulses `coreStart` once, and `sdoEn` is 0 for the whole conversion.
- R2: While no conversion or readback is in progress, `sdoEn` is 1 with `sdoOut` at 0 when the convert and select pins are both low, and `sdoEn` is 0 otherwise. Both pins low is also the state after reset.
- R3: When `coreDone` arrives during a valid conversion, the port captures `coreResult` and drives `sdoEn`=1, `sdoOut`=0 until the first serial-clock falling edge.
- R4: If the select pin is seen high once the conversion has run for `MIN_CONV_CYCLES` system cycles, the busy low is never produced, and the port returns to idle with `sdoEn`=0 while the convert pin stays high. Later serial-clock edges leave it there.
- R5: A select pin that is high at the start and returns low before `MIN_CONV_CYCLES` does not suppress the busy low.
- R6: Serial-clock falling edges 1 to 14 put result bits 13 down to 0 on `sdoOut`, one bit per edge. Each bit holds through the following rising edge.
- R7: The 15th serial-clock falling edge of a readback returns `sdoEn` to 0.
- R8: The select pin rising during readback returns `sdoEn` to 0 at once. The remaining bits are discarded, and further serial-clock edges have no effect.
- R9: The convert pin falling during conversion or readback aborts to idle. A `coreDone` that arrives afterwards has no effect.
- R10: A rising edge on the convert pin while the select pin is low starts no conversion, and `coreStart` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cnvPin | input | 1 | Convert pin from the host, asynchronous |
| sdiPin | input | 1 | Serial-select pin from the host, asynchronous |
| sckPin | input | 1 | Serial clock from the host, asynchronous |
| coreDone | input | 1 | One-cycle strobe from the converter core when its result is ready |
| coreResult | input | DATA_W | Conversion result from the core, valid with `coreDone` |
| coreStart | output | 1 | One-cycle strobe asking the core to begin converting |
| sdoOut | output | 1 | Serial data value |
| sdoEn | output | 1 | Drive enable for the data line; 0 models high impedance |

## Verification
On every cycle, the assertions check the state transitions. These are: start only with select high, abort whenever the convert pin is low, the busy hand-off and its suppression on a late select, and the exit on a select rise during readback. They also keep the bit counter within the readback length and check that the shift register holds between strobes. Only the bench scenarios show the values on the data line, because those require a reference result. This covers the MSB-first order of two different results, the release after the 15th falling edge, the absence of activity after an abort, and the low-when-idle rule at the pins.

// File: rtl/adc_sport_pkg.sv
package adc_sport_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2
  } portState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture core result
    logic shift;    // advance to next bit
    logic drvEn;    // enable the data line
    logic drvData;  // drive shift register MSB instead of constant low
  } dpCtrl_t;

endpackage

// File: rtl/sport_sync.sv
module sport_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RISE_MASK = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] levelOut,
  output logic [WIDTH-1:0] edgeOut
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chainQ;
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainQ <= '0;
      prevQ  <= '0;
    end else begin
      chainQ <= {chainQ[STAGES-2:0], asyncIn};
      prevQ  <= chainQ[LAST];
    end
  end

  assign levelOut = chainQ[LAST];

  for (genvar i = 0; i < WIDTH; i++) begin : g_edge
    if (RISE_MASK[i]) begin : g_rise
      assign edgeOut[i] = chainQ[LAST][i] & ~prevQ[i];
    end else begin : g_fall
      assign edgeOut[i] = ~chainQ[LAST][i] & prevQ[i];
    end
  end

endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import adc_sport_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int MIN_CONV_CYCLES = 20
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cnvS,
  input  logic    cnvRise,
  input  logic    sdiS,
  input  logic    sdiRise,
  input  logic    sckFall,
  input  logic    coreDone,
  output logic    coreStart,
  output dpCtrl_t dpCtrl
);

  localparam int CNT_W = $clog2(MIN_CONV_CYCLES + 1);
  localparam int BIT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CONV_CYCLES);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W);

  portState_t       state;
  logic [CNT_W-1:0] convCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             busyOk;
  logic             startCond;
  logic             lateSdi;
  logic             readExit;

  assign startCond = (state == ST_IDLE) && cnvRise && sdiS;
  assign lateSdi   = sdiS && (convCnt == CNT_MAX);
  assign readExit  = !cnvS || sdiRise;
  assign coreStart = startCond;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      convCnt <= '0;
      bitCnt  <= '0;
      busyOk  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startCond) begin
            state   <= ST_CONV;
            convCnt <= '0;
            busyOk  <= 1'b1;
          end
        end
        ST_CONV: begin
          if (!cnvS) begin
            state <= ST_IDLE;
          end else if (coreDone) begin
            if (busyOk && !lateSdi) begin
              state  <= ST_READ;
              bitCnt <= '0;
            end else begin
              state <= ST_IDLE;
            end
          end else begin
            if (lateSdi) busyOk <= 1'b0;
            if (convCnt != CNT_MAX) convCnt <= convCnt + 1'b1;
          end
        end
        ST_READ: begin
          if (readExit) begin
            state <= ST_IDLE;
          end else if (sckFall) begin
            if (bitCnt == BIT_LAST) state <= ST_IDLE;
            else bitCnt <= bitCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    dpCtrl = '0;
    dpCtrl.load = (state == ST_CONV) && coreDone;
    dpCtrl.shift = (state == ST_READ) && !readExit && sckFall && (bitCnt != BIT_LAST);
    unique case (state)
      ST_IDLE: dpCtrl.drvEn = !cnvS && !sdiS;
      ST_READ: begin
        dpCtrl.drvEn   = 1'b1;
        dpCtrl.drvData = 1'b1;
      end
      default: dpCtrl.drvEn = 1'b0;
    endcase
  end

  AST_START_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cnvRise && sdiS) |=> (state == ST_CONV && !dpCtrl.drvEn)); // R1
  AST_NO_START_SDI_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cnvRise && !sdiS) |=> (state == ST_IDLE)); // R10
  AST_BUSY_HANDOFF: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && cnvS && coreDone && busyOk && !sdiS) |=> (state == ST_READ && bitCnt == '0)); // R3
  AST_LATE_SDI_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV && cnvS && coreDone && !busyOk) |=> (state == ST_IDLE)); // R4
  AST_CNV_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE && !cnvS) |=> (state == ST_IDLE)); // R9
  AST_SDI_END_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && sdiRise) |=> (state == ST_IDLE)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= BIT_LAST); // R7

endmodule

// File: rtl/sport_datapath.sv
module sport_datapath
  import adc_sport_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [DATA_W-1:0] coreResult,
  output logic              sdoOut,
  output logic              sdoEn
);

  localparam int SR_W = DATA_W + 1;

  // MSB slot starts at 0 so the busy low comes out of the same register
  logic [SR_W-1:0] shiftQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (dpCtrl.load) begin
      shiftQ <= {1'b0, coreResult};
    end else if (dpCtrl.shift) begin
      shiftQ <= {shiftQ[SR_W-2:0], 1'b0};
    end
  end

  assign sdoOut = dpCtrl.drvData & shiftQ[SR_W-1];
  assign sdoEn  = dpCtrl.drvEn;

  AST_DATA_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    dpCtrl.drvData |-> dpCtrl.drvEn); // R6
  AST_LOAD_SHIFT_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(dpCtrl.load && dpCtrl.shift)); // R6
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!dpCtrl.load && !dpCtrl.shift) |=> $stable(shiftQ)); // R6

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sport_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int MIN_CONV_CYCLES = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cnvPin,
  input  logic              sdiPin,
  input  logic              sckPin,
  input  logic              coreDone,
  input  logic [DATA_W-1:0] coreResult,
  output logic              coreStart,
  output logic              sdoEn,
  output logic              sdoOut
);

  // bit 0 convert (rise), bit 1 select (rise), bit 2 serial clock (fall)
  localparam logic [2:0] EDGE_RISE = 3'b011;

  logic [2:0] pinLevel;
  logic [2:0] pinEdge;
  dpCtrl_t    dpCtrl;

  sport_sync #(
    .WIDTH    (3),
    .STAGES   (SYNC_STAGES),
    .RISE_MASK(EDGE_RISE)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({sckPin, sdiPin, cnvPin}),
    .levelOut(pinLevel),
    .edgeOut (pinEdge)
  );

  sport_ctrl #(
    .DATA_W         (DATA_W),
    .MIN_CONV_CYCLES(MIN_CONV_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cnvS     (pinLevel[0]),
    .cnvRise  (pinEdge[0]),
    .sdiS     (pinLevel[1]),
    .sdiRise  (pinEdge[1]),
    .sckFall  (pinEdge[2]),
    .coreDone (coreDone),
    .coreStart(coreStart),
    .dpCtrl   (dpCtrl)
  );

  sport_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .coreResult(coreResult),
    .sdoOut    (sdoOut),
    .sdoEn     (sdoEn)
  );

endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 14;
  localparam int CORE_LAT = 30;
  localparam int WATCHDOG = 100000;

  typedef struct {
    logic  en;
    logic  val;
    string tag;
  } sdoItem_t;

  logic clk = 1'b0;
  logic rstN;
  logic cnvPin, sdiPin, sckPin;
  logic coreDone = 1'b0;
  logic [DATA_W-1:0] coreResult = '0;
  logic coreStart, sdoEn, sdoOut;
  logic [DATA_W-1:0] nextResult = '0;

  int vectors = 0;
  int miscompares = 0;
  int startSeen = 0;
  int startExp = 0;
  sdoItem_t sbQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .cnvPin    (cnvPin),
    .sdiPin    (sdiPin),
    .sckPin    (sckPin),
    .coreDone  (coreDone),
    .coreResult(coreResult),
    .coreStart (coreStart),
    .sdoEn     (sdoEn),
    .sdoOut    (sdoOut)
  );

  // converter core model
  initial begin
    forever begin
      @(posedge clk);
      if (coreStart) begin
        startSeen++;
        repeat (CORE_LAT) @(posedge clk);
        coreDone   <= 1'b1;
        coreResult <= nextResult;
        @(posedge clk);
        coreDone   <= 1'b0;
      end
    end
  end

  // monitor: pops expected items and compares against the pins
  initial begin
    forever begin
      @(negedge clk);
      while (sbQ.size() > 0) begin
        sdoItem_t it;
        it = sbQ.pop_front();
        vectors++;
        if (sdoEn !== it.en || (it.en && sdoOut !== it.val)) begin
          miscompares++;
          $display("FAIL %s: sdoEn/sdoOut actual %b/%b expected %b/%b",
                   it.tag, sdoEn, sdoOut, it.en, it.val);
        end
      end
    end
  end

  task automatic expectSdo(input logic en, input logic val, input string tag);
    sdoItem_t it;
    it.en = en;
    it.val = val;
    it.tag = tag;
    @(posedge clk);
    sbQ.push_back(it);
  endtask

  task automatic checkStarts(input string tag);
    @(negedge clk);
    vectors++;
    if (startSeen != startExp) begin
      miscompares++;
      $display("FAIL %s: start count actual %0d expected %0d", tag, startSeen, startExp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startConv(input logic [DATA_W-1:0] d);
    nextResult = d;
    @(negedge clk) sdiPin = 1'b1;
    waitNeg(3);
    cnvPin = 1'b1;
    waitNeg(6);
    expectSdo(1'b0, 1'b0, "R1 hiz in conversion");
    startExp++;
    checkStarts("R1");
    sdiPin = 1'b0;
  endtask

  task automatic sckRise();
    @(negedge clk) sckPin = 1'b1;
    waitNeg(6);
  endtask

  task automatic sckFall();
    @(negedge clk) sckPin = 1'b0;
    waitNeg(6);
  endtask

  task automatic readBits(input logic [DATA_W-1:0] d, input int n);
    for (int k = 0; k < n; k++) begin
      sckRise();
      if (k == 0) expectSdo(1'b1, 1'b0, "R3 busy low held");
      else expectSdo(1'b1, d[DATA_W-k], "R6 bit held over rise");
      sckFall();
      expectSdo(1'b1, d[DATA_W-1-k], "R6 bit after fall");
    end
  endtask

  task automatic idleLow(input string tag);
    @(negedge clk);
    cnvPin = 1'b0;
    sdiPin = 1'b0;
    waitNeg(6);
    expectSdo(1'b1, 1'b0, tag);
  endtask

  initial begin
    rstN = 1'b0;
    cnvPin = 1'b0;
    sdiPin = 1'b0;
    sckPin = 1'b0;
    waitNeg(5);
    expectSdo(1'b1, 1'b0, "R2 reset state low");
    @(negedge clk) rstN = 1'b1;
    waitNeg(4);

    // R2: select high alone releases the line
    sdiPin = 1'b1;
    waitNeg(6);
    expectSdo(1'b0, 1'b0, "R2 idle select high");
    idleLow("R2 idle both low");

    // A: full readback, early select return (R5)
    startConv(14'h35A6);
    waitNeg(40);
    expectSdo(1'b1, 1'b0, "R3 R5 busy low after done");
    readBits(14'h35A6, DATA_W);
    sckRise();
    sckFall();
    expectSdo(1'b0, 1'b0, "R7 release after 15th fall");
    sckRise();
    sckFall();
    expectSdo(1'b0, 1'b0, "R7 stays released");
    idleLow("R2 back to idle low");

    // B: select rise ends readback
    startConv(14'h1C3B);
    waitNeg(40);
    expectSdo(1'b1, 1'b0, "R3 busy low");
    readBits(14'h1C3B, 5);
    @(negedge clk) sdiPin = 1'b1;
    waitNeg(6);
    expectSdo(1'b0, 1'b0, "R8 release on select rise");
    sckRise();
    sckFall();
    expectSdo(1'b0, 1'b0, "R8 later edges ignored");
    idleLow("R2 idle after R8");

    // C: select high late in conversion
    startConv(14'h2AAA);
    waitNeg(17);
    sdiPin = 1'b1;
    waitNeg(30);
    expectSdo(1'b0, 1'b0, "R4 no busy low");
    @(negedge clk) sdiPin = 1'b0;
    waitNeg(6);
    expectSdo(1'b0, 1'b0, "R4 convert still high");
    sckRise();
    sckFall();
    expectSdo(1'b0, 1'b0, "R4 no readback");
    idleLow("R2 idle after R4");

    // D: convert falls mid conversion
    startConv(14'h0F0F);
    waitNeg(4);
    cnvPin = 1'b0;
    waitNeg(6);
    expectSdo(1'b1, 1'b0, "R9 aborted to idle low");
    waitNeg(40);
    expectSdo(1'b1, 1'b0, "R9 late done ignored");
    sckRise();
    sckFall();
    expectSdo(1'b1, 1'b0, "R9 no readback");

    // R10: convert rise with select low
    @(negedge clk) cnvPin = 1'b1;
    waitNeg(10);
    expectSdo(1'b0, 1'b0, "R10 no conversion, line released");
    checkStarts("R10");
    waitNeg(40);
    sckRise();
    sckFall();
    expectSdo(1'b0, 1'b0, "R10 nothing to read");
    checkStarts("R10");
    idleLow("R2 idle after R10");

    // E: second full readback with edge-bit pattern
    startConv(14'h2001);
    waitNeg(40);
    expectSdo(1'b1, 1'b0, "R3 busy low");
    readBits(14'h2001, DATA_W);
    sckRise();
    sckFall();
    expectSdo(1'b0, 1'b0, "R7 release after 15th fall");
    @(negedge clk) cnvPin = 1'b0;
    waitNeg(6);
    expectSdo(1'b1, 1'b0, "R2 idle low at end");

    waitNeg(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", WATCHDOG);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule